// File: doc/BRIEF.md
# Interval Timer with Count Snapshot

A 32-bit down-counter for generating timeouts and periodic ticks. Software sets it up through a small word-addressed register bus with 16-bit data. The period is written as two 16-bit halves. Strobe bits in the control word start and stop the counter. A mode bit picks between stopping after one timeout and reloading to run again. A timeout sets a sticky flag, which drives the interrupt output when the interrupt is enabled. Software clears the flag by writing the status word.

Software can read the live count without tearing between the two halves. A write to the low snapshot word freezes all 32 bits of the count into a holding register. The two halves of that register are then read at leisure. With the period set to all ones and reload on, the counter runs freely, and the snapshot serves as a time base.

Top module: `ivt_top`

## Requirements
- R1: After reset the status, control and both snapshot words read 0, both period words read 0xFFFF, the counter is stopped and `irqOut` is 0.
- R2: Word addresses 0 to 5 select status, control, period low, period high, snapshot low and snapshot high. These are byte offsets 0, 4, 8, 12, 16 and 20 divided by four. Written period halves read back unchanged, and addresses 6 and 7 read 0.
- R3: Control bit 0 enables the interrupt and bit 1 selects continuous reload; both read back as written. Bit 2 is a START strobe and bit 3 is a STOP strobe; both always read as 0. If both strobes are written at once, the counter ends up stopped.
- R4: Status bit 0 is the timeout flag and status bit 1 is 1 while the counter runs. After START from idle with period value P, the flag sets on the (P+1)-th rising edge after the START write edge, and not before.
- R5: With continuous mode off, the counter stops at timeout, reloads the period into the count and raises no further timeout.
- R6: With continuous mode on, the counter keeps running after a timeout, reloads the period, and times out again every P+1 cycles.
- R7: Writing either period word stops the counter and loads the full new 32-bit period into the count.
- R8: Writing the snapshot low word copies the current 32-bit count into the snapshot register. The low and high snapshot words then return that frozen value. Writes to the snapshot high word have no effect.
- R9: Any write to the status word clears the timeout flag. If a timeout occurs on the same edge, the flag stays set.
- R10: `irqOut` is 1 exactly when the timeout flag is set and the interrupt enable bit is 1.
- R11: STOP freezes the count at its present value. START while running does not reload the count. START while stopped loads the count from the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Word address of the register accessed |
| regWrEn | input | 1 | Write strobe, one write per cycle it is high |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr`, combinational |
| irqOut | output | 1 | Timeout interrupt, flag gated by enable |

## Verification
The hardest case to reach from the ports is a status-clear write that lands on the same edge as a new timeout. The flag must survive that collision. The bench gets there by running continuous mode with a short period. It counts cycles from the START edge, so the clear write falls exactly on the edge of the second timeout, and it then reads the status word. Snapshot reads at known cycle offsets stand in for direct access to the count. They show a reload, a freeze after STOP and a START that does not reload.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  // word addresses inside the timer window
  localparam int ADR_STATUS   = 0;
  localparam int ADR_CONTROL  = 1;
  localparam int ADR_PER_BASE = 2;
  localparam int ADR_SNP_BASE = 4;

  // control word bit positions
  localparam int CB_IRQEN = 0;
  localparam int CB_CONT  = 1;
  localparam int CB_START = 2;
  localparam int CB_STOP  = 3;

  // strobes from the control side to the counter datapath
  typedef struct packed {
    logic loadPeriod;
    logic startReq;
    logic stopReq;
    logic capture;
  } ivt_strobe_t;

endpackage

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               dpRunning,
  input  logic               dpTimeout,
  input  logic [COUNT_W-1:0] dpSnap,
  output ivt_strobe_t        strobes,
  output logic [COUNT_W-1:0] periodNext,
  output logic               contMode,
  output logic               irqEn,
  output logic               toFlag
);

  localparam int NUM_HALVES = COUNT_W / DATA_W;

  logic [COUNT_W-1:0]    periodReg;
  logic [NUM_HALVES-1:0] perHit;
  logic                  ctrlHit;
  logic                  statHit;
  logic                  snapHit;

  assign ctrlHit = regWrEn && (regAddr == ADDR_W'(ADR_CONTROL));
  assign statHit = regWrEn && (regAddr == ADDR_W'(ADR_STATUS));
  assign snapHit = regWrEn && (regAddr == ADDR_W'(ADR_SNP_BASE));

  // one slice per period half, merged with the write data on a hit
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_perHalf
    assign perHit[h] = regWrEn && (regAddr == ADDR_W'(ADR_PER_BASE + h));
    assign periodNext[h*DATA_W +: DATA_W] =
      perHit[h] ? regWrData : periodReg[h*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodReg <= '1;
      contMode  <= 1'b0;
      irqEn     <= 1'b0;
      toFlag    <= 1'b0;
    end else begin
      periodReg <= periodNext;
      if (ctrlHit) begin
        contMode <= regWrData[CB_CONT];
        irqEn    <= regWrData[CB_IRQEN];
      end
      // a fresh timeout outranks a clear on the same edge
      if (dpTimeout)    toFlag <= 1'b1;
      else if (statHit) toFlag <= 1'b0;
    end
  end

  always_comb begin
    strobes.loadPeriod = |perHit;
    strobes.stopReq    = (|perHit) || (ctrlHit && regWrData[CB_STOP]);
    strobes.startReq   = ctrlHit && regWrData[CB_START];
    strobes.capture    = snapHit;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(ADR_STATUS)) begin
      regRdData[0] = toFlag;
      regRdData[1] = dpRunning;
    end else if (regAddr == ADDR_W'(ADR_CONTROL)) begin
      regRdData[CB_IRQEN] = irqEn;
      regRdData[CB_CONT]  = contMode;
    end
    for (int h = 0; h < NUM_HALVES; h++) begin
      if (regAddr == ADDR_W'(ADR_PER_BASE + h))
        regRdData = periodReg[h*DATA_W +: DATA_W];
      if (regAddr == ADDR_W'(ADR_SNP_BASE + h))
        regRdData = dpSnap[h*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/ivt_datapath.sv
module ivt_datapath
  import ivt_pkg::*;
#(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ivt_strobe_t        strobes,
  input  logic [COUNT_W-1:0] periodNext,
  input  logic               contMode,
  output logic [COUNT_W-1:0] count,
  output logic               running,
  output logic               timeout,
  output logic [COUNT_W-1:0] snap
);

  logic atZero;

  assign atZero  = (count == '0);
  assign timeout = running && atZero && !strobes.stopReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '1;
      running <= 1'b0;
      snap    <= '0;
    end else begin
      if (strobes.capture) snap <= count;
      if (strobes.stopReq) begin
        running <= 1'b0;
        if (strobes.loadPeriod) count <= periodNext;
      end else if (strobes.startReq && !running) begin
        running <= 1'b1;
        count   <= periodNext;
      end else if (running) begin
        if (atZero) begin
          count   <= periodNext;
          running <= contMode;
        end else begin
          count <= count - COUNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/ivt_top.sv
module ivt_top
  import ivt_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);

  ivt_strobe_t        strobes;
  logic [COUNT_W-1:0] periodNext;
  logic [COUNT_W-1:0] dpCount;
  logic [COUNT_W-1:0] dpSnap;
  logic               dpRunning;
  logic               dpTimeout;
  logic               contMode;
  logic               irqEn;
  logic               toFlag;

  ivt_ctrl #(.COUNT_W(COUNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .dpRunning (dpRunning),
    .dpTimeout (dpTimeout),
    .dpSnap    (dpSnap),
    .strobes   (strobes),
    .periodNext(periodNext),
    .contMode  (contMode),
    .irqEn     (irqEn),
    .toFlag    (toFlag)
  );

  ivt_datapath #(.COUNT_W(COUNT_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .periodNext(periodNext),
    .contMode  (contMode),
    .count     (dpCount),
    .running   (dpRunning),
    .timeout   (dpTimeout),
    .snap      (dpSnap)
  );

  assign irqOut = toFlag && irqEn;

endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
  parameter int COUNT_W = 32,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrEn,
  input logic [DATA_W-1:0]  regWrData,
  input logic [COUNT_W-1:0] dpCount,
  input logic               dpRunning,
  input logic               contMode,
  input logic               toFlag
);

  logic perWrite;
  logic ctrlWrite;
  logic statWrite;
  logic expiring;

  assign perWrite  = regWrEn && (regAddr == ADDR_W'(2) || regAddr == ADDR_W'(3));
  assign ctrlWrite = regWrEn && (regAddr == ADDR_W'(1));
  assign statWrite = regWrEn && (regAddr == ADDR_W'(0));
  assign expiring  = dpRunning && (dpCount == '0);

  p_count_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dpRunning && dpCount != '0 && !regWrEn) |=> (dpCount == $past(dpCount) - COUNT_W'(1)));

  p_flag_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toFlag) |-> ($past(dpRunning) && $past(dpCount) == '0));

  p_oneshot_halt_r5: assert property (@(posedge clk) disable iff (!rstN)
    (expiring && !contMode && !regWrEn) |=> !dpRunning);

  p_cont_rerun_r6: assert property (@(posedge clk) disable iff (!rstN)
    (expiring && contMode && !regWrEn) |=> dpRunning);

  p_period_halts_r7: assert property (@(posedge clk) disable iff (!rstN)
    perWrite |=> !dpRunning);

  p_stop_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && regWrData[3]) |=> !dpRunning);

  p_clear_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statWrite && !expiring) |=> !toFlag);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!dpRunning && !regWrEn) |=> $stable(dpCount));

endmodule

bind ivt_top ivt_checker #(.COUNT_W(COUNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .dpCount  (dpCount),
  .dpRunning(dpRunning),
  .contMode (contMode),
  .toFlag   (toFlag)
);

// File: tb/tb_ivt_top.sv
`timescale 1ns/1ps
module tb_ivt_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irqOut;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  ivt_top dut (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .irqOut   (irqOut)
  );

  // {we, addr[2:0], wdata[15:0], expected read of addr afterwards[15:0]}
  localparam int NV = 12;
  localparam logic [35:0] VECS [NV] = '{
    {1'b1, 3'd1, 16'h0003, 16'h0003},  // R3 mode bits read back
    {1'b1, 3'd1, 16'h000F, 16'h0003},  // R3 strobes read 0
    {1'b0, 3'd0, 16'h0000, 16'h0000},  // R3 stop won, idle
    {1'b1, 3'd1, 16'h0001, 16'h0001},  // R3
    {1'b1, 3'd2, 16'h1234, 16'h1234},  // R2 period low
    {1'b1, 3'd3, 16'hABCD, 16'hABCD},  // R2 period high
    {1'b0, 3'd2, 16'h0000, 16'h1234},  // R2
    {1'b1, 3'd6, 16'hFFFF, 16'h0000},  // R2 unmapped
    {1'b1, 3'd7, 16'hFFFF, 16'h0000},  // R2 unmapped
    {1'b1, 3'd5, 16'h5555, 16'h0000},  // R8 snapshot high write ignored
    {1'b0, 3'd0, 16'h0000, 16'h0000},  // R7 still stopped
    {1'b1, 3'd1, 16'h0000, 16'h0000}   // R3
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    regAddr   = a;
    regWrData = d;
    regWrEn   = 1'b1;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    waitN(3);
    // R1 reset state
    rd(0, v); check("R1 status", {16'h0, v}, 32'h0);
    rd(1, v); check("R1 control", {16'h0, v}, 32'h0);
    rd(2, v); check("R1 period low", {16'h0, v}, 32'hFFFF);
    rd(3, v); check("R1 period high", {16'h0, v}, 32'hFFFF);
    rd(4, v); check("R1 snap low", {16'h0, v}, 32'h0);
    rd(5, v); check("R1 snap high", {16'h0, v}, 32'h0);
    check("R1 irq", {31'h0, irqOut}, 32'h0);
    rstN = 1'b1;
    waitN(1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][35]) wr(VECS[i][34:32], VECS[i][31:16]);
      rd(VECS[i][34:32], v);
      check($sformatf("R2/R3/R8 vector %0d", i), {16'h0, v}, {16'h0, VECS[i][15:0]});
    end

    // R4 / R5: one-shot, period 5, irq enabled
    wr(2, 16'd5); wr(3, 16'd0);
    wr(1, 16'h0005);
    waitN(5);
    rd(0, v); check("R4 not yet expired", {16'h0, v}, 32'h2);
    waitN(1);
    rd(0, v); check("R4 expired on P+1", {16'h0, v}, 32'h1);
    check("R10 irq with enable", {31'h0, irqOut}, 32'h1);
    waitN(20);
    rd(0, v); check("R5 stays stopped", {16'h0, v}, 32'h1);
    wr(4, 16'h0);
    rd(4, v); check("R5 count reloaded", {16'h0, v}, 32'd5);

    // R10 / R9
    wr(1, 16'h0000);
    check("R10 irq masked", {31'h0, irqOut}, 32'h0);
    rd(0, v); check("R10 flag kept", {16'h0, v}, 32'h1);
    wr(0, 16'h0);
    rd(0, v); check("R9 clear", {16'h0, v}, 32'h0);

    // R6 / R9: continuous, period 3 -> timeouts on edges 4, 8, 12 after start
    wr(2, 16'd3);
    wr(1, 16'h0006);
    waitN(3);
    rd(0, v); check("R6 running", {16'h0, v}, 32'h2);
    waitN(1);
    rd(0, v); check("R6 first timeout", {16'h0, v}, 32'h3);
    wr(0, 16'h0);
    rd(0, v); check("R9 cleared while running", {16'h0, v}, 32'h2);
    waitN(2);
    wr(0, 16'h0);  // lands on the second timeout edge
    rd(0, v); check("R9 timeout beats clear", {16'h0, v}, 32'h3);
    wr(0, 16'h0);
    rd(0, v); check("R9 plain clear", {16'h0, v}, 32'h2);
    waitN(2);
    rd(0, v); check("R6 no early timeout", {16'h0, v}, 32'h2);
    waitN(1);
    rd(0, v); check("R6 third timeout", {16'h0, v}, 32'h3);

    // R7
    wr(2, 16'd100);
    rd(0, v); check("R7 period write stops", {16'h0, v}, 32'h1);
    wr(0, 16'h0);
    wr(4, 16'h0);
    rd(4, v); check("R7 new period loaded", {16'h0, v}, 32'd100);

    // R8: high half and freezing
    wr(3, 16'd2);
    wr(1, 16'h0004);
    waitN(10);
    wr(4, 16'h0);
    rd(4, v); check("R8 snap low", {16'h0, v}, 32'h005A);
    rd(5, v); check("R8 snap high", {16'h0, v}, 32'h0002);
    waitN(7);
    rd(4, v); check("R8 frozen", {16'h0, v}, 32'h005A);
    wr(5, 16'h1111);
    rd(5, v); check("R8 high write ignored", {16'h0, v}, 32'h0002);
    rd(4, v); check("R8 low unchanged", {16'h0, v}, 32'h005A);

    // R11
    wr(1, 16'h0004);
    wr(4, 16'h0);
    rd(4, v); check("R11 start while running no reload", {16'h0, v}, 32'h0050);
    wr(1, 16'h0008);
    waitN(15);
    wr(4, 16'h0);
    rd(4, v); check("R11 stop freezes", {16'h0, v}, 32'h004F);
    rd(0, v); check("R11 stopped", {16'h0, v}, 32'h0);
    wr(1, 16'h0004);
    wr(4, 16'h0);
    rd(4, v); check("R11 start from idle reloads", {16'h0, v}, 32'h0064);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule